// File: doc/BRIEF.md
# Hamming SEC-DED Codec

This block protects a data word with a Hamming code plus one overall parity bit. It corrects any single flipped bit and flags any two flipped bits. The encoder side takes a K-bit data word and returns a CW-bit codeword. The decoder side takes a CW-bit codeword that may have been corrupted. It returns the recovered data word and a two-bit status that tells whether the word was clean, corrected or beyond repair.

The parameter M sets the size of the code: N = 2^M − 1 Hamming positions, K = N − M data bits and CW = N + 1 codeword bits. The default M = 4 gives 11 data bits in a 16-bit codeword. The Hamming positions are numbered 1..N and sit at codeword bits 1..N. Check bits take the power-of-two positions, and data bits fill the remaining positions in rising order, with data bit 0 at the lowest. Codeword bit 0 holds the overall parity. The decoder's syndrome is the XOR of the indices of all set bits among positions 1..N. A nonzero syndrome therefore names the position of a single flipped bit.

Each side has a valid input and a valid output, with one register stage. An asynchronous active-low reset clears both stages and is released on the clock.

Top module: `hsd_codec`

## Requirements
- R1: `enc_valid_out` is high in the cycle after a clock edge at which `enc_valid_in` was high, and low in the cycle after an edge at which it was low.
- R2: In every codeword the encoder emits, codeword bit 0 makes the XOR of all CW bits zero. Data bit j sits at the (j+1)-th non-power-of-two position among 1..N.
- R3: For each i < M, check bit 2^i is the XOR of the data bits whose position index has bit i set, so a clean codeword has syndrome zero.
- R4: When the decoder receives an unaltered codeword, it returns the original data with status 0 (clean). Status 3 is never produced.
- R5: A single flipped bit at any position 1..N is repaired. The decoder returns the original data with status 1 (corrected).
- R6: A flip of codeword bit 0 alone leaves the data unchanged and gives status 1 (corrected).
- R7: Any two flipped bits give status 2 (uncorrectable). The data output then carries the data-position bits of the received word without any correction.
- R8: `dec_valid_out` is high in the cycle after a clock edge at which `dec_valid_in` was high, and low otherwise.
- R9: While reset is asserted, `enc_valid_out` and `dec_valid_out` are low.
- R10: An edge at which a side's valid input is low leaves that side's data and status outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_valid_in | input | 1 | Encoder input word is valid |
| enc_data_in | input | K | Data word to encode |
| enc_valid_out | output | 1 | Encoder output is valid |
| enc_code_out | output | CW | Encoded codeword, bit 0 = overall parity |
| dec_valid_in | input | 1 | Decoder input word is valid |
| dec_code_in | input | CW | Received codeword |
| dec_valid_out | output | 1 | Decoder output is valid |
| dec_data_out | output | K | Recovered data word |
| dec_status_out | output | 2 | 0 clean, 1 corrected, 2 uncorrectable |

## Verification
The bench flips every one of the N Hamming positions in turn. A wrong data-to-position mapping or a wrong syndrome weight would then repair the wrong bit and corrupt the data. It also flips the parity bit alone. A design that treated a zero syndrome as clean would report status 0 there instead of 1. Random double flips, including pairs that contain bit 0, check for "repairs" of a third bit that would damage the word instead of leaving it raw and flagged. Idle cycles between words check that the output registers keep their contents when no new word arrives.

// File: rtl/hsd_pkg.sv
package hsd_pkg;

  typedef enum logic [1:0] {
    HSD_CLEAN = 2'd0,
    HSD_FIXED = 2'd1,
    HSD_FAIL  = 2'd2
  } hsd_status_e;

  function automatic bit is_pow2(input int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  // zero-based data index held at a non-power-of-two position p
  function automatic int data_idx(input int p);
    return p - 1 - $clog2(p);
  endfunction

endpackage

// File: rtl/hsd_syndrome.sv
module hsd_syndrome #(
  parameter int M = 4,
  localparam int N = (1 << M) - 1
) (
  input  logic [N-1:0] pos_bits,   // pos_bits[p-1] is Hamming position p
  output logic [M-1:0] syn
);

  always_comb begin
    syn = '0;
    for (int p = 1; p <= N; p++) begin
      if (pos_bits[p-1]) syn = syn ^ M'(p);
    end
  end

endmodule

// File: rtl/hsd_encoder.sv
module hsd_encoder #(
  parameter int M = 4,
  localparam int N  = (1 << M) - 1,
  localparam int K  = N - M,
  localparam int CW = N + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_in,
  input  logic [K-1:0]  data_in,
  output logic          valid_out,
  output logic [CW-1:0] code_out
);

  logic [N:1]    base;
  logic [CW-1:0] word_nxt;
  logic [M-1:0]  chk;
  logic          vld_q;
  logic [CW-1:0] code_q;

  // place data at non-power positions, check positions zero
  for (genvar p = 1; p <= N; p++) begin : g_pos
    if (hsd_pkg::is_pow2(p)) begin : g_chk
      assign base[p]     = 1'b0;
      assign word_nxt[p] = chk[$clog2(p)];
    end else begin : g_dat
      assign base[p]     = data_in[hsd_pkg::data_idx(p)];
      assign word_nxt[p] = data_in[hsd_pkg::data_idx(p)];
    end
  end

  hsd_syndrome #(.M(M)) u_syn (
    .pos_bits (base),
    .syn      (chk)
  );

  assign word_nxt[0] = ^word_nxt[CW-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= valid_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        code_q <= '0;
    else if (valid_in) code_q <= word_nxt;
  end

  assign valid_out = vld_q;
  assign code_out  = code_q;

endmodule

// File: rtl/hsd_decoder.sv
module hsd_decoder #(
  parameter int M = 4,
  localparam int N  = (1 << M) - 1,
  localparam int K  = N - M,
  localparam int CW = N + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_in,
  input  logic [CW-1:0] code_in,
  output logic          valid_out,
  output logic [K-1:0]  data_out,
  output logic [1:0]    status_out
);

  import hsd_pkg::*;

  logic [M-1:0]  syn;
  logic          par_err;
  logic [CW-1:0] fixed;
  hsd_status_e   st_nxt;
  logic [K-1:0]  data_nxt;
  logic          vld_q;
  logic [K-1:0]  data_q;
  hsd_status_e   st_q;

  hsd_syndrome #(.M(M)) u_syn (
    .pos_bits (code_in[CW-1:1]),
    .syn      (syn)
  );

  assign par_err = ^code_in;

  always_comb begin
    fixed  = code_in;
    st_nxt = HSD_CLEAN;
    if (par_err) begin
      st_nxt = HSD_FIXED;
      if (syn != '0) fixed[syn] = ~code_in[syn];
    end else if (syn != '0) begin
      st_nxt = HSD_FAIL;
    end
  end

  for (genvar p = 1; p <= N; p++) begin : g_ext
    if (!hsd_pkg::is_pow2(p)) begin : g_dat
      assign data_nxt[hsd_pkg::data_idx(p)] = fixed[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= valid_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      st_q   <= HSD_CLEAN;
    end else if (valid_in) begin
      data_q <= data_nxt;
      st_q   <= st_nxt;
    end
  end

  assign valid_out  = vld_q;
  assign data_out   = data_q;
  assign status_out = st_q;

endmodule

// File: rtl/hsd_codec.sv
module hsd_codec #(
  parameter int M = 4,
  localparam int N  = (1 << M) - 1,
  localparam int K  = N - M,
  localparam int CW = N + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enc_valid_in,
  input  logic [K-1:0]  enc_data_in,
  output logic          enc_valid_out,
  output logic [CW-1:0] enc_code_out,
  input  logic          dec_valid_in,
  input  logic [CW-1:0] dec_code_in,
  output logic          dec_valid_out,
  output logic [K-1:0]  dec_data_out,
  output logic [1:0]    dec_status_out
);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  // assert at once, release two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end

  assign rst_sync_n = rst_pipe[1];

  hsd_encoder #(.M(M)) u_enc (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .valid_in  (enc_valid_in),
    .data_in   (enc_data_in),
    .valid_out (enc_valid_out),
    .code_out  (enc_code_out)
  );

  hsd_decoder #(.M(M)) u_dec (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .valid_in   (dec_valid_in),
    .code_in    (dec_code_in),
    .valid_out  (dec_valid_out),
    .data_out   (dec_data_out),
    .status_out (dec_status_out)
  );

endmodule

// File: rtl/hsd_codec_chk.sv
module hsd_codec_chk #(
  parameter int M = 4,
  localparam int N  = (1 << M) - 1,
  localparam int K  = N - M,
  localparam int CW = N + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enc_valid_in,
  input logic          enc_valid_out,
  input logic [CW-1:0] enc_code_out,
  input logic          dec_valid_in,
  input logic [CW-1:0] dec_code_in,
  input logic          dec_valid_out,
  input logic [K-1:0]  dec_data_out,
  input logic [1:0]    dec_status_out
);

  AST_ENC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid_in |=> enc_valid_out);                                   // R1
  AST_ENC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !enc_valid_in |=> !enc_valid_out);                                 // R1
  AST_ENC_EVEN_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid_out |-> (^enc_code_out) == 1'b0);                        // R2
  AST_ENC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !enc_valid_in |=> $stable(enc_code_out));                          // R10
  AST_DEC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_in |=> dec_valid_out);                                   // R8
  AST_DEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid_in |=> !dec_valid_out);                                 // R8
  AST_DEC_ODD_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_in && (^dec_code_in)) |=> dec_status_out == 2'd1);      // R5
  AST_DEC_EVEN_NOT_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_in && !(^dec_code_in)) |=> dec_status_out != 2'd1);     // R7
  AST_DEC_LEGAL_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_out |-> dec_status_out != 2'd3);                         // R4
  AST_DEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid_in |=> ($stable(dec_data_out) && $stable(dec_status_out))); // R10

endmodule

bind hsd_codec hsd_codec_chk #(.M(M)) u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .enc_valid_in   (enc_valid_in),
  .enc_valid_out  (enc_valid_out),
  .enc_code_out   (enc_code_out),
  .dec_valid_in   (dec_valid_in),
  .dec_code_in    (dec_code_in),
  .dec_valid_out  (dec_valid_out),
  .dec_data_out   (dec_data_out),
  .dec_status_out (dec_status_out)
);

// File: tb/hsd_codec_tb.sv
module hsd_codec_tb;

  localparam int M  = 4;
  localparam int N  = (1 << M) - 1;
  localparam int K  = N - M;
  localparam int CW = N + 1;

  logic          clk;
  logic          rst_n;
  logic          enc_valid_in;
  logic [K-1:0]  enc_data_in;
  logic          enc_valid_out;
  logic [CW-1:0] enc_code_out;
  logic          dec_valid_in;
  logic [CW-1:0] dec_code_in;
  logic          dec_valid_out;
  logic [K-1:0]  dec_data_out;
  logic [1:0]    dec_status_out;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  hsd_codec #(.M(M)) u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .enc_valid_in   (enc_valid_in),
    .enc_data_in    (enc_data_in),
    .enc_valid_out  (enc_valid_out),
    .enc_code_out   (enc_code_out),
    .dec_valid_in   (dec_valid_in),
    .dec_code_in    (dec_code_in),
    .dec_valid_out  (dec_valid_out),
    .dec_data_out   (dec_data_out),
    .dec_status_out (dec_status_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [CW-1:0] model_enc(input logic [K-1:0] d);
    logic [CW-1:0] c;
    int di;
    logic par;
    c  = '0;
    di = 0;
    for (int p = 1; p <= N; p++) begin
      if ((p & (p - 1)) != 0) begin
        c[p] = d[di];
        di++;
      end
    end
    for (int i = 0; i < M; i++) begin
      par = 1'b0;
      for (int p = 1; p <= N; p++)
        if (((p >> i) & 1) == 1 && p != (1 << i)) par = par ^ c[p];
      c[1 << i] = par;
    end
    c[0] = ^c[CW-1:1];
    return c;
  endfunction

  function automatic logic [K-1:0] raw_data(input logic [CW-1:0] c);
    logic [K-1:0] d;
    int di;
    d  = '0;
    di = 0;
    for (int p = 1; p <= N; p++) begin
      if ((p & (p - 1)) != 0) begin
        d[di] = c[p];
        di++;
      end
    end
    return d;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_enc(input logic [K-1:0] d);
    logic [CW-1:0] exp;
    exp = model_enc(d);
    @(negedge clk);
    enc_valid_in = 1'b1;
    enc_data_in  = d;
    @(negedge clk);
    enc_valid_in = 1'b0;
    enc_data_in  = ~d;
    check(enc_valid_out == 1'b1, "R1", 32'(enc_valid_out), 32'd1);
    check(enc_code_out == exp, "R2/R3", 32'(enc_code_out), 32'(exp));
    @(negedge clk);
    check(enc_valid_out == 1'b0, "R1", 32'(enc_valid_out), 32'd0);
    check(enc_code_out == exp, "R10", 32'(enc_code_out), 32'(exp));
  endtask

  task automatic do_dec(input logic [CW-1:0] c, input logic [K-1:0] exp_d,
                        input logic [1:0] exp_s, input string req);
    @(negedge clk);
    dec_valid_in = 1'b1;
    dec_code_in  = c;
    @(negedge clk);
    dec_valid_in = 1'b0;
    dec_code_in  = ~c;
    check(dec_valid_out == 1'b1, "R8", 32'(dec_valid_out), 32'd1);
    check(dec_data_out == exp_d, req, 32'(dec_data_out), 32'(exp_d));
    check(dec_status_out == exp_s, req, 32'(dec_status_out), 32'(exp_s));
    @(negedge clk);
    check(dec_valid_out == 1'b0, "R8", 32'(dec_valid_out), 32'd0);
    check(dec_data_out == exp_d && dec_status_out == exp_s, "R10",
          32'(dec_data_out), 32'(exp_d));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [K-1:0]  d;
    logic [CW-1:0] c;
    logic [CW-1:0] e;
    int a;
    int b;
    void'($urandom(32'd20240611));
    enc_valid_in = 1'b0;
    enc_data_in  = '0;
    dec_valid_in = 1'b0;
    dec_code_in  = '0;
    rst_n        = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R9: outputs idle during reset
    check(enc_valid_out == 1'b0, "R9", 32'(enc_valid_out), 32'd0);
    check(dec_valid_out == 1'b0, "R9", 32'(dec_valid_out), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R3 directed encodes
    do_enc('0);
    do_enc('1);
    for (int j = 0; j < K; j++) do_enc(K'(1) << j);

    // R4 clean decode
    d = K'(11'h5A3);
    c = model_enc(d);
    do_dec(c, d, 2'd0, "R4");
    do_dec(model_enc('1), '1, 2'd0, "R4");

    // R5 single flip at every Hamming position
    for (int p = 1; p <= N; p++) begin
      d = K'($urandom);
      c = model_enc(d);
      c[p] = ~c[p];
      do_dec(c, d, 2'd1, "R5");
    end

    // R6 parity bit only
    d = K'(11'h2C7);
    c = model_enc(d);
    c[0] = ~c[0];
    do_dec(c, d, 2'd1, "R6");

    // R7 double flips, one pair with bit 0
    d = K'(11'h1F0);
    c = model_enc(d);
    c[0] = ~c[0];
    c[5] = ~c[5];
    do_dec(c, raw_data(c), 2'd2, "R7");
    for (int t = 0; t < 20; t++) begin
      d = K'($urandom);
      c = model_enc(d);
      a = int'($urandom % CW);
      b = int'(($urandom % (CW - 1) + 1 + a) % CW);
      c[a] = ~c[a];
      c[b] = ~c[b];
      do_dec(c, raw_data(c), 2'd2, "R7");
    end

    // random mix through the encoder
    for (int t = 0; t < 60; t++) begin
      d = K'($urandom);
      do_enc(d);
      e = enc_code_out;
      a = int'($urandom % 3);
      if (a == 0) begin
        do_dec(e, d, 2'd0, "R4");
      end else if (a == 1) begin
        b = int'($urandom % CW);
        e[b] = ~e[b];
        do_dec(e, d, 2'd1, "R5");
      end else begin
        b = int'($urandom % CW);
        e[b] = ~e[b];
        b = (b + 1 + int'($urandom % (CW - 1))) % CW;
        e[b] = ~e[b];
        do_dec(e, raw_data(e), 2'd2, "R7");
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule